// File: doc/BRIEF.md
# Serial Port Interrupt Request Logic

This block keeps the status flags of a multi-channel serial interface and turns them into four interrupt requests per channel: receive error, receive data full, transmit data empty and transmit end. The serial datapath reports events as one-cycle set pulses. Software clears flags with strobes. An interrupt controller acknowledges one encoded source at a time, and a transfer controller acknowledges receive-full or transmit-empty service on separate lines.

Each request is a level. It is the AND of its flag condition and a registered enable bit. A fixed-priority encoder reports the highest-ranked pending request as a source index with a valid bit. Only the receive-full and transmit-empty requests are offered to the transfer controller as trigger lines. The transmit-end flag is cleared whenever the transmit-empty flag is cleared. As a result, a transmit-end request can vanish unserviced when the transmit-empty request is taken first.

Top module: `sirq_top`

## Requirements
- R1: After reset, every channel has transmit-empty and transmit-end flags at 1, all other flags at 0 and all enables at 0, so no request, trigger or `pri_valid` is asserted.
- R2: A set pulse sets its flag at the next clock edge. The receive-error condition is the OR of the overrun, parity and framing flags.
- R3: Enables are sampled at each clock edge. `en_rx` gates both the receive-error and receive-full requests, `en_tx` gates the transmit-empty request, and `en_tend` gates the transmit-end request.
- R4: A software clear strobe clears its flag at the next edge. `clr_err` clears all three error flags together.
- R5: When a set pulse and any clear reach the same flag in the same cycle, the flag ends up set.
- R6: Every clear of the transmit-empty flag (software, interrupt acknowledge or transfer acknowledge) also clears the transmit-end flag at the same edge, unless `set_tend` is pulsed in that cycle.
- R7: `dma_rx_trig` equals the receive-full request and `dma_tx_trig` equals the transmit-empty request. `dma_ack_rx` clears the receive-full flag and `dma_ack_tx` clears the transmit-empty flag. Receive-error and transmit-end requests raise no trigger.
- R8: `int_ack` with `int_ack_idx` clears the acknowledged source at the next edge. Source 0 clears all error flags, source 1 clears the receive-full flag, source 2 clears transmit-empty and transmit-end, and source 3 clears only transmit-end.
- R9: `pri_valid` is 1 when any request is pending. `pri_idx` is {channel, source} of the pending request with the lowest value channel*4+source. Source codes are 0 = receive error, 1 = receive full, 2 = transmit empty, 3 = transmit end, and the channel is in the bits above bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_ovr | input | NUM_CH | Overrun event pulse per channel |
| set_par | input | NUM_CH | Parity error event pulse per channel |
| set_frm | input | NUM_CH | Framing error event pulse per channel |
| set_rxf | input | NUM_CH | Receive data full event pulse |
| set_txe | input | NUM_CH | Transmit data empty event pulse |
| set_tend | input | NUM_CH | Transmit end event pulse |
| en_rx | input | NUM_CH | Receive-side request enable |
| en_tx | input | NUM_CH | Transmit-empty request enable |
| en_tend | input | NUM_CH | Transmit-end request enable |
| clr_err | input | NUM_CH | Software clear of all error flags |
| clr_rxf | input | NUM_CH | Software clear of receive-full flag |
| clr_txe | input | NUM_CH | Software clear of transmit-empty flag (also transmit-end) |
| int_ack | input | 1 | Interrupt controller acknowledge strobe |
| int_ack_idx | input | IDX_W | Acknowledged source index {channel, source} |
| dma_ack_rx | input | NUM_CH | Transfer controller served receive-full |
| dma_ack_tx | input | NUM_CH | Transfer controller served transmit-empty |
| req_eri | output | NUM_CH | Receive error request |
| req_rxi | output | NUM_CH | Receive data full request |
| req_txi | output | NUM_CH | Transmit data empty request |
| req_tei | output | NUM_CH | Transmit end request |
| dma_rx_trig | output | NUM_CH | Transfer trigger for receive-full |
| dma_tx_trig | output | NUM_CH | Transfer trigger for transmit-empty |
| pri_valid | output | 1 | Some request is pending |
| pri_idx | output | IDX_W | Highest-priority pending source |

## Verification
The encoder and request gating are tried with all 256 patterns of the eight request lines. Each pattern is built by clearing every flag and pulsing chosen sets in the same cycle. This shows whether set wins over clear, whether each line maps to the right source, and whether the lowest-ranked pending source always wins. The error source chosen rotates between overrun, parity and framing, so each error flag reaches the receive-error request. Directed sequences cover enable gating, each clear path and each acknowledge path. One of them is the case where taking the transmit-empty request first makes a pending transmit-end request disappear.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int SRC_PER_CH = 4;

  typedef enum logic [1:0] {
    SRC_ERR  = 2'd0,
    SRC_RXF  = 2'd1,
    SRC_TXE  = 2'd2,
    SRC_TEND = 2'd3
  } src_e;

  typedef struct packed {
    logic ovr;
    logic par;
    logic frm;
    logic rxf;
    logic txe;
    logic tend;
  } chan_flags_t;

  localparam chan_flags_t FLAGS_RESET = '{ovr: 1'b0, par: 1'b0, frm: 1'b0,
                                          rxf: 1'b0, txe: 1'b1, tend: 1'b1};
endpackage

// File: rtl/sirq_ackdec.sv
module sirq_ackdec #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             ack,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [NUM_SRC-1:0] ack_vec
);
  always_comb begin
    ack_vec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (ack && (ack_idx == IDX_W'(i))) ack_vec[i] = 1'b1;
    end
  end
endmodule

// File: rtl/sirq_chan.sv
module sirq_chan
  import sirq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_ovr,
  input  logic set_par,
  input  logic set_frm,
  input  logic set_rxf,
  input  logic set_txe,
  input  logic set_tend,
  input  logic en_rx,
  input  logic en_tx,
  input  logic en_tend,
  input  logic clr_err,
  input  logic clr_rxf,
  input  logic clr_txe,
  input  logic [SRC_PER_CH-1:0] ack,
  input  logic dma_ack_rx,
  input  logic dma_ack_tx,
  output logic [SRC_PER_CH-1:0] req
);
  chan_flags_t flags_q, flags_d;
  logic en_rx_q, en_tx_q, en_tend_q;
  logic kill_err, kill_rxf, kill_txe, kill_tend;

  // Merge every clear source per flag; the transmit-empty clear also kills transmit-end.
  always_comb begin
    kill_err  = clr_err | ack[SRC_ERR];
    kill_rxf  = clr_rxf | ack[SRC_RXF] | dma_ack_rx;
    kill_txe  = clr_txe | ack[SRC_TXE] | dma_ack_tx;
    kill_tend = kill_txe | ack[SRC_TEND];

    // Set has priority over clear.
    flags_d.ovr  = set_ovr  | (flags_q.ovr  & ~kill_err);
    flags_d.par  = set_par  | (flags_q.par  & ~kill_err);
    flags_d.frm  = set_frm  | (flags_q.frm  & ~kill_err);
    flags_d.rxf  = set_rxf  | (flags_q.rxf  & ~kill_rxf);
    flags_d.txe  = set_txe  | (flags_q.txe  & ~kill_txe);
    flags_d.tend = set_tend | (flags_q.tend & ~kill_tend);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q   <= FLAGS_RESET;
      en_rx_q   <= 1'b0;
      en_tx_q   <= 1'b0;
      en_tend_q <= 1'b0;
    end else begin
      flags_q   <= flags_d;
      en_rx_q   <= en_rx;
      en_tx_q   <= en_tx;
      en_tend_q <= en_tend;
    end
  end

  always_comb begin
    req[SRC_ERR]  = en_rx_q   & (flags_q.ovr | flags_q.par | flags_q.frm);
    req[SRC_RXF]  = en_rx_q   & flags_q.rxf;
    req[SRC_TXE]  = en_tx_q   & flags_q.txe;
    req[SRC_TEND] = en_tend_q & flags_q.tend;
  end
endmodule

// File: rtl/sirq_prio.sv
module sirq_prio #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               valid,
  output logic [IDX_W-1:0]   idx
);
  // Lowest index wins: scan from the top so the last hit is the winner.
  always_comb begin
    valid = |req;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/sirq_top.sv
module sirq_top
  import sirq_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int NUM_SRC = NUM_CH * SRC_PER_CH,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_ovr,
  input  logic [NUM_CH-1:0] set_par,
  input  logic [NUM_CH-1:0] set_frm,
  input  logic [NUM_CH-1:0] set_rxf,
  input  logic [NUM_CH-1:0] set_txe,
  input  logic [NUM_CH-1:0] set_tend,
  input  logic [NUM_CH-1:0] en_rx,
  input  logic [NUM_CH-1:0] en_tx,
  input  logic [NUM_CH-1:0] en_tend,
  input  logic [NUM_CH-1:0] clr_err,
  input  logic [NUM_CH-1:0] clr_rxf,
  input  logic [NUM_CH-1:0] clr_txe,
  input  logic              int_ack,
  input  logic [IDX_W-1:0]  int_ack_idx,
  input  logic [NUM_CH-1:0] dma_ack_rx,
  input  logic [NUM_CH-1:0] dma_ack_tx,
  output logic [NUM_CH-1:0] req_eri,
  output logic [NUM_CH-1:0] req_rxi,
  output logic [NUM_CH-1:0] req_txi,
  output logic [NUM_CH-1:0] req_tei,
  output logic [NUM_CH-1:0] dma_rx_trig,
  output logic [NUM_CH-1:0] dma_tx_trig,
  output logic              pri_valid,
  output logic [IDX_W-1:0]  pri_idx
);
  logic [NUM_SRC-1:0] ack_flat;
  logic [NUM_SRC-1:0] req_flat;

  sirq_ackdec #(.NUM_SRC(NUM_SRC)) u_ackdec (
    .ack     (int_ack),
    .ack_idx (int_ack_idx),
    .ack_vec (ack_flat)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SRC_PER_CH-1:0] ch_req;

    sirq_chan u_chan (
      .clk        (clk),
      .rst        (rst),
      .set_ovr    (set_ovr[c]),
      .set_par    (set_par[c]),
      .set_frm    (set_frm[c]),
      .set_rxf    (set_rxf[c]),
      .set_txe    (set_txe[c]),
      .set_tend   (set_tend[c]),
      .en_rx      (en_rx[c]),
      .en_tx      (en_tx[c]),
      .en_tend    (en_tend[c]),
      .clr_err    (clr_err[c]),
      .clr_rxf    (clr_rxf[c]),
      .clr_txe    (clr_txe[c]),
      .ack        (ack_flat[c*SRC_PER_CH +: SRC_PER_CH]),
      .dma_ack_rx (dma_ack_rx[c]),
      .dma_ack_tx (dma_ack_tx[c]),
      .req        (ch_req)
    );

    assign req_flat[c*SRC_PER_CH +: SRC_PER_CH] = ch_req;
    assign req_eri[c]     = ch_req[SRC_ERR];
    assign req_rxi[c]     = ch_req[SRC_RXF];
    assign req_txi[c]     = ch_req[SRC_TXE];
    assign req_tei[c]     = ch_req[SRC_TEND];
    assign dma_rx_trig[c] = ch_req[SRC_RXF];
    assign dma_tx_trig[c] = ch_req[SRC_TXE];
  end

  sirq_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .req   (req_flat),
    .valid (pri_valid),
    .idx   (pri_idx)
  );
endmodule

// File: rtl/sirq_chk.sv
module sirq_chk #(
  parameter int NUM_CH = 2,
  localparam int IDX_W = $clog2(NUM_CH * 4)
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] set_ovr,
  input logic [NUM_CH-1:0] set_rxf,
  input logic [NUM_CH-1:0] set_tend,
  input logic [NUM_CH-1:0] en_rx,
  input logic [NUM_CH-1:0] clr_txe,
  input logic [NUM_CH-1:0] dma_ack_rx,
  input logic [NUM_CH-1:0] req_eri,
  input logic [NUM_CH-1:0] req_rxi,
  input logic [NUM_CH-1:0] req_txi,
  input logic [NUM_CH-1:0] req_tei,
  input logic [NUM_CH-1:0] dma_rx_trig,
  input logic [NUM_CH-1:0] dma_tx_trig,
  input logic              pri_valid,
  input logic [IDX_W-1:0]  pri_idx
);
  logic any_req;
  assign any_req = |{req_eri, req_rxi, req_txi, req_tei};

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !any_req);

  p_valid_tracks_req_r9: assert property (@(posedge clk) disable iff (rst)
    pri_valid == any_req);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    p_err_sets_r2: assert property (@(posedge clk) disable iff (rst)
      (set_ovr[c] && en_rx[c]) |=> req_eri[c]);

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
      (set_rxf[c] && en_rx[c]) |=> req_rxi[c]);

    p_tend_follows_r6: assert property (@(posedge clk) disable iff (rst)
      (clr_txe[c] && !set_tend[c]) |=> !req_tei[c]);

    p_dma_clears_r7: assert property (@(posedge clk) disable iff (rst)
      (dma_ack_rx[c] && !set_rxf[c]) |=> !req_rxi[c]);

    p_trig_match_r7: assert property (@(posedge clk) disable iff (rst)
      (dma_rx_trig[c] == req_rxi[c]) && (dma_tx_trig[c] == req_txi[c]));
  end
endmodule

bind sirq_top sirq_chk #(.NUM_CH(NUM_CH)) u_sirq_chk (
  .clk         (clk),
  .rst         (rst),
  .set_ovr     (set_ovr),
  .set_rxf     (set_rxf),
  .set_tend    (set_tend),
  .en_rx       (en_rx),
  .clr_txe     (clr_txe),
  .dma_ack_rx  (dma_ack_rx),
  .req_eri     (req_eri),
  .req_rxi     (req_rxi),
  .req_txi     (req_txi),
  .req_tei     (req_tei),
  .dma_rx_trig (dma_rx_trig),
  .dma_tx_trig (dma_tx_trig),
  .pri_valid   (pri_valid),
  .pri_idx     (pri_idx)
);

// File: tb/tb_sirq_top.sv
`timescale 1ns/1ps
module tb_sirq_top;
  localparam int NCH = 2;
  localparam int IW  = 3;

  logic clk = 1'b0;
  logic rst;
  logic [NCH-1:0] set_ovr, set_par, set_frm, set_rxf, set_txe, set_tend;
  logic [NCH-1:0] en_rx, en_tx, en_tend, clr_err, clr_rxf, clr_txe;
  logic int_ack;
  logic [IW-1:0] int_ack_idx;
  logic [NCH-1:0] dma_ack_rx, dma_ack_tx;
  logic [NCH-1:0] req_eri, req_rxi, req_txi, req_tei, dma_rx_trig, dma_tx_trig;
  logic pri_valid;
  logic [IW-1:0] pri_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sirq_top #(.NUM_CH(NCH)) dut (.*);

  function automatic logic [7:0] reqs();
    logic [7:0] v;
    for (int c = 0; c < NCH; c++)
      v[c*4 +: 4] = {req_tei[c], req_txi[c], req_rxi[c], req_eri[c]};
    return v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_strobes();
    set_ovr = '0; set_par = '0; set_frm = '0; set_rxf = '0; set_txe = '0; set_tend = '0;
    clr_err = '0; clr_rxf = '0; clr_txe = '0;
    int_ack = 1'b0; int_ack_idx = '0; dma_ack_rx = '0; dma_ack_tx = '0;
  endtask

  // Drive current inputs across one rising edge, then drop strobes.
  task automatic step();
    @(negedge clk);
    idle_strobes();
  endtask

  initial begin
    #1900000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_strobes();
    en_rx = '0; en_tx = '0; en_tend = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: nothing pending after reset
    chk("R1 reqs", reqs(), 0);
    chk("R1 valid", pri_valid, 0);
    chk("R1 trig", {dma_rx_trig, dma_tx_trig}, 0);
    // R1/R3: enabling exposes reset flag values (txe, tend = 1)
    en_rx = '1; en_tx = '1; en_tend = '1;
    step();
    chk("R1 flags", reqs(), 8'hCC);
    chk("R9 reset prio", {pri_valid, pri_idx}, {1'b1, 3'd2});

    // R2 R5 R7 R9: exhaustive request-pattern sweep
    for (int p = 0; p < 256; p++) begin
      int low;
      clr_err = '1; clr_rxf = '1; clr_txe = '1;
      for (int c = 0; c < NCH; c++) begin
        if (p[c*4]) begin
          case ((p + c) % 3)
            0: set_ovr[c] = 1'b1;
            1: set_par[c] = 1'b1;
            default: set_frm[c] = 1'b1;
          endcase
        end
        set_rxf[c]  = p[c*4+1];
        set_txe[c]  = p[c*4+2];
        set_tend[c] = p[c*4+3];
      end
      step();
      low = 0;
      for (int i = 7; i >= 0; i--) if (p[i]) low = i;
      chk("R2 R5 sweep reqs", reqs(), p);
      chk("R9 sweep prio", {pri_valid, pri_idx}, (p != 0) ? (8 + low) : 0);
      chk("R7 sweep trig", {dma_tx_trig, dma_rx_trig},
          {p[6], p[2], p[5], p[1]});
    end

    // R4: clear all flags by software
    set_ovr = '1; set_par = '1; set_frm = '1; set_rxf = '1; set_txe = '1; set_tend = '1;
    step();
    clr_err = 2'b01;
    step();
    chk("R4 err clear ch0", {req_eri[1], req_eri[0]}, 2'b10);
    clr_err = 2'b10; clr_rxf = 2'b11;
    step();
    chk("R4 rx clear", {req_eri, req_rxi}, 0);

    // R6: software clear of txe also drops tend
    clr_txe = 2'b01;
    step();
    chk("R6 txe clr kills tend", {req_txi, req_tei}, 4'b1010);
    // R6: set_tend in same cycle wins
    set_txe = 2'b01; set_tend = 2'b01;
    step();
    clr_txe = 2'b01; set_tend = 2'b01;
    step();
    chk("R6 tend set wins", {req_txi[0], req_tei[0]}, 2'b01);

    // R3: enable gating
    set_ovr = 2'b01; set_rxf = 2'b01; set_txe = 2'b01; set_tend = 2'b01;
    en_rx = 2'b00; en_tx = 2'b00; en_tend = 2'b00;
    step();
    chk("R3 all gated", reqs(), 0);
    chk("R3 no valid", pri_valid, 0);
    en_rx = 2'b01;
    step();
    chk("R3 rx enable", reqs() & 8'h0F, 4'b0011);
    en_rx = 2'b00; en_tx = 2'b01;
    step();
    chk("R3 tx enable", reqs() & 8'h0F, 4'b0100);
    en_tx = 2'b00; en_tend = 2'b01;
    step();
    chk("R3 tend enable", reqs() & 8'h0F, 4'b1000);
    en_rx = '1; en_tx = '1; en_tend = '1;
    step();

    // R7: transfer acknowledge clears rxf / txe (and tend), trigger follows
    chk("R7 trig before", {dma_rx_trig[0], dma_tx_trig[0]}, 2'b11);
    dma_ack_rx = 2'b01; dma_ack_tx = 2'b01;
    step();
    chk("R7 dma clears", {req_rxi[0], req_txi[0], req_tei[0], dma_rx_trig[0], dma_tx_trig[0]}, 0);
    chk("R7 eri no trig", {req_eri[0], dma_rx_trig[0]}, 2'b10);

    // R8: interrupt acknowledges
    int_ack = 1'b1; int_ack_idx = 3'd0;
    step();
    chk("R8 ack err", req_eri[0], 0);
    set_rxf = 2'b10;
    step();
    chk("R9 ch1 rxi idx", {pri_valid, pri_idx}, {1'b1, 3'd5});
    int_ack = 1'b1; int_ack_idx = 3'd5;
    step();
    chk("R8 ack rx ch1", req_rxi[1], 0);
    // R8 R6: transmit-empty taken first, pending transmit-end is lost
    clr_txe = '1; clr_rxf = '1; clr_err = '1;
    step();
    set_txe = 2'b01; set_tend = 2'b01;
    step();
    chk("R9 txi over tei", {pri_valid, pri_idx}, {1'b1, 3'd2});
    int_ack = 1'b1; int_ack_idx = 3'd2;
    step();
    chk("R8 tei lost", {req_txi[0], req_tei[0], pri_valid}, 0);
    // R8: tend ack leaves txe
    set_txe = 2'b01; set_tend = 2'b01;
    step();
    int_ack = 1'b1; int_ack_idx = 3'd3;
    step();
    chk("R8 ack tend only", {req_txi[0], req_tei[0]}, 2'b10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule